// File: doc/BRIEF.md
# Bus Hang Timeout Counter

This block watches a two-wire serial bus controller for stalls. A 14-bit counter advances while the controller's serial interrupt flag is low. If no bus event is raised and serviced before the counter passes its top value, a sticky timeout flag is set. The block also drives an interrupt request line that merges this timeout with the controller's own serial interrupt. Software clears the timeout by writing a one to it.

The counter runs only when three things hold: the serial controller is enabled, the counter enable is set, and no interrupt is pending. A pending serial interrupt keeps the counter cleared. Counting resumes from zero once software services that interrupt, so the count measures silence since the last handled event. A prescale select picks one of two count rates: one count per clock, or one count every fourth clock. The divide-by-four rate comes from a clock enable, not a divided clock. All pins are plain control or status levels and strobes. No data stream passes through the block, so no handshake is needed.

Top module: `bus_hang_watchdog`

## Requirements
- R1: After reset the timeout flag is 0, the counter and prescaler are 0, and `irq` is 0 while `sif` is 0.
- R2: With `tick_sel`=0 and the counter running, `timeout_flag` becomes 1 right after the 16384th rising edge of continuous running. It is 0 after the 16383rd edge.
- R3: With `tick_sel`=1 the counter advances once every fourth clock. `timeout_flag` becomes 1 right after the 65536th running edge and is 0 after the 65535th.
- R4: While `sif` is 1 the counter is held at zero. After `sif` returns to 0, a full 16384 running edges (at `tick_sel`=0) are needed again before a timeout.
- R5: While `cnt_en` is 0 the counter is cleared and no timeout occurs.
- R6: While `ctrl_en` is 0 the counter is cleared and no timeout occurs.
- R7: `timeout_flag` is sticky. A one-cycle `to_clr_wr` pulse clears it on the next edge. The same pulse has no effect when the flag is already 0.
- R8: While `timeout_flag` is 1 the counter stays at zero and does not wrap. After a clear, a full 16384 running edges pass before the next timeout.
- R9: `irq` is a level equal to `sif` OR `timeout_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Counter enable; 0 stops and clears the count |
| tick_sel | input | 1 | Count rate: 0 = every clock, 1 = every fourth clock |
| ctrl_en | input | 1 | Serial controller enable |
| sif | input | 1 | Serial interrupt flag level from the controller |
| to_clr_wr | input | 1 | Write-one strobe that clears the timeout flag |
| timeout_flag | output | 1 | Sticky timeout flag |
| irq | output | 1 | Combined interrupt request level |

## Verification
The assertions assume the following about the inputs:
- All inputs are synchronous to `clk` and settle between rising edges.
- `sif` is a level that the controller holds until software services it.
- `to_clr_wr` is a strobe from a register write.

Under these assumptions, `sif` or either enable being low must leave the counter at zero on the following cycle. A timeout may only appear after a cycle in which the counter was allowed to run.

The bench changes every input one nanosecond after a rising edge and holds each pattern for whole numbers of cycles. Each run starts from a fresh reset, so the prescaler phase and the count are known at every check.

// File: rtl/bhw_pkg.sv
package bhw_pkg;
  typedef enum logic {
    TICK_EVERY = 1'b0,
    TICK_DIV4  = 1'b1
  } tick_sel_e;

  localparam int unsigned DEF_CNT_W = 14;
  localparam int unsigned DEF_DIV_W = 2;
endpackage

// File: rtl/bhw_prescaler.sv
module bhw_prescaler #(
  parameter int unsigned DIV_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic slow,
  output logic tick
);
  logic [DIV_W-1:0] phase_q;

  // phase restarts whenever counting is held, giving a known tick position
  always_ff @(posedge clk) begin
    if (!rst_n)    phase_q <= '0;
    else if (!run) phase_q <= '0;
    else           phase_q <= phase_q + 1'b1;
  end

  assign tick = run & (slow ? (&phase_q) : 1'b1);
endmodule

// File: rtl/bhw_counter.sv
module bhw_counter #(
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  output logic             ovf,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (!run) cnt_q <= '0;
    else if (tick) cnt_q <= cnt_q + 1'b1;
  end

  assign ovf = run & tick & (&cnt_q);
  assign cnt = cnt_q;
endmodule

// File: rtl/bhw_flag.sv
module bhw_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_q;

  // a set in the same cycle as a clear wins, so no timeout is lost
  always_ff @(posedge clk) begin
    if (!rst_n)   flag_q <= 1'b0;
    else if (set) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end

  assign flag = flag_q;
endmodule

// File: rtl/bus_hang_watchdog.sv
module bus_hang_watchdog
  import bhw_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W,
  parameter int unsigned DIV_W = DEF_DIV_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cnt_en,
  input  logic tick_sel,
  input  logic ctrl_en,
  input  logic sif,
  input  logic to_clr_wr,
  output logic timeout_flag,
  output logic irq
);
  logic             run;
  logic             tick;
  logic             ovf;
  logic [CNT_W-1:0] cnt_q;
  logic             flag;

  assign run = ctrl_en & cnt_en & ~sif & ~flag;

  bhw_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .slow (tick_sel == TICK_DIV4),
    .tick (tick)
  );

  bhw_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .tick (tick),
    .ovf  (ovf),
    .cnt  (cnt_q)
  );

  bhw_flag u_flag (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (ovf),
    .clr  (to_clr_wr),
    .flag (flag)
  );

  assign timeout_flag = flag;
  assign irq          = sif | flag;
endmodule

// File: rtl/bhw_checker.sv
module bhw_checker #(
  parameter int unsigned CNT_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_en,
  input logic             ctrl_en,
  input logic             sif,
  input logic             to_clr_wr,
  input logic             timeout_flag,
  input logic             irq,
  input logic [CNT_W-1:0] cnt_q
);
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == CNT_W'($past(cnt_q) + 1'b1) || cnt_q == '0));

  assert_rise_needs_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_flag) |-> $past(cnt_en && ctrl_en && !sif));

  assert_sif_holds_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sif |=> (cnt_q == '0));

  assert_enable_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> (cnt_q == '0));

  assert_ctrl_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> (cnt_q == '0));

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_flag && !to_clr_wr) |=> timeout_flag);

  assert_flag_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_flag && to_clr_wr) |=> !timeout_flag);

  assert_hold_after_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_flag |=> (cnt_q == '0));

  assert_irq_on_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_flag || sif) |-> irq);

  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!timeout_flag && !sif) |-> !irq);
endmodule

bind bus_hang_watchdog bhw_checker #(.CNT_W(CNT_W)) u_bhw_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cnt_en      (cnt_en),
  .ctrl_en     (ctrl_en),
  .sif         (sif),
  .to_clr_wr   (to_clr_wr),
  .timeout_flag(timeout_flag),
  .irq         (irq),
  .cnt_q       (cnt_q)
);

// File: tb/test_bus_hang_watchdog.sv
`timescale 1ns/1ps
module test_bus_hang_watchdog;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_en = 1'b0, tick_sel = 1'b0, ctrl_en = 1'b0, sif = 1'b0, to_clr_wr = 1'b0;
  logic timeout_flag, irq;
  int total = 0;
  int failed = 0;

  always #2.5 clk = ~clk;

  bus_hang_watchdog i_bus_hang_watchdog (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .tick_sel(tick_sel),
    .ctrl_en(ctrl_en), .sif(sif), .to_clr_wr(to_clr_wr),
    .timeout_flag(timeout_flag), .irq(irq)
  );

  // vector: [24] tick_sel [23] cnt_en [22] ctrl_en [21] sif [20:1] edges [0] expected flag
  localparam logic [24:0] VEC [5] = '{
    {1'b0, 1'b1, 1'b1, 1'b0, 20'd16384, 1'b1},
    {1'b1, 1'b1, 1'b1, 1'b0, 20'd65536, 1'b1},
    {1'b0, 1'b0, 1'b1, 1'b0, 20'd17000, 1'b0},
    {1'b0, 1'b1, 1'b0, 1'b0, 20'd17000, 1'b0},
    {1'b0, 1'b1, 1'b1, 1'b1, 20'd17000, 1'b0}
  };

  function automatic string vec_req(int i);
    case (i)
      0: return "R2";
      1: return "R3";
      2: return "R5";
      3: return "R6";
      default: return "R4";
    endcase
  endfunction

  task automatic check(string req, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    edges(2);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (198000) @(posedge clk);
    total++;
    failed++;
    $display("FAIL watchdog run did not finish actual=1 expected=0");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    edges(1);
    // R1: reset values
    do_reset();
    check("R1", "flag after reset", timeout_flag, 1'b0);
    check("R1", "irq after reset", irq, 1'b0);

    for (int i = 0; i < 5; i++) begin
      tick_sel = 1'b0; cnt_en = 1'b0; ctrl_en = 1'b0; sif = 1'b0;
      do_reset();
      tick_sel = VEC[i][24]; cnt_en = VEC[i][23]; ctrl_en = VEC[i][22]; sif = VEC[i][21];
      edges(int'(VEC[i][20:1]) - 1);
      check(vec_req(i), "flag one edge early", timeout_flag, 1'b0);
      edges(1);
      check(vec_req(i), "flag at end", timeout_flag, VEC[i][0]);
      check("R9", "irq level", irq, VEC[i][21] | VEC[i][0]);
    end

    // R4: pending sif restarts the count from zero
    tick_sel = 1'b0; cnt_en = 1'b1; ctrl_en = 1'b1; sif = 1'b0;
    do_reset();
    edges(10000);
    sif = 1'b1;
    edges(5);
    check("R9", "irq with sif", irq, 1'b1);
    check("R4", "flag while sif", timeout_flag, 1'b0);
    sif = 1'b0;
    edges(16383);
    check("R4", "no timeout before full window", timeout_flag, 1'b0);
    edges(1);
    check("R4", "timeout after full window", timeout_flag, 1'b1);
    check("R9", "irq from flag", irq, 1'b1);

    // R7 and R8: sticky flag, clear, no wrap
    edges(100);
    check("R7", "flag sticky", timeout_flag, 1'b1);
    to_clr_wr = 1'b1;
    edges(1);
    to_clr_wr = 1'b0;
    check("R7", "flag cleared", timeout_flag, 1'b0);
    check("R9", "irq quiet", irq, 1'b0);
    edges(16383);
    check("R8", "count held at zero while flagged", timeout_flag, 1'b0);
    edges(1);
    check("R8", "full window after clear", timeout_flag, 1'b1);

    // R7: clear with flag already zero has no effect
    cnt_en = 1'b0;
    do_reset();
    to_clr_wr = 1'b1;
    edges(1);
    to_clr_wr = 1'b0;
    check("R7", "clear on idle flag", timeout_flag, 1'b0);
    check("R7", "irq on idle clear", irq, 1'b0);

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule